// File: doc/BRIEF.md
# Command Stream Address Classifier

This block watches a stream of register writes travelling toward an engine. Each write carries a class ID, a word offset and a data value. For each write it gives a one-bit verdict: does the target register hold a memory address that a later stage must validate or relocate? The block only classifies. Relocation, memory checks and command fetch happen elsewhere.

Writes in the host class are judged by their offset alone. Engine writes use a two-step method interface. A write to the method-select register picks a method. A following write to the method-data register carries that method's argument. When a select write arrives, the block works out whether the chosen method takes an address and stores the answer in a flag. Every later data write returns that stored flag until the next select write replaces it.

Top module: `cmd_addr_classifier`

## Requirements
- R1: After reset `verdict_valid_o` is 0. The stored flag is clear, so an engine data write (word offset 0x11) that arrives before any select write gets verdict 0.
- R2: When the class is the host class (1), the verdict is 1 exactly when the word offset is 0x2B. A host-class write to word offset 0x10 or 0x11 neither reads nor changes the stored flag.
- R3: A non-host write to the method-select register (word offset 0x10) always gets verdict 0.
- R4: On a select write the method byte address is the data value shifted left by 2, with no upper bits dropped. The flag is set when this address lies in 0x400..0x5DC, both bounds included.
- R5: The flag is also set when the method byte address lies in 0x720..0x738, both bounds included.
- R6: A select write whose method byte address is outside both ranges clears the flag. Examples are 0x3FC, 0x5E0, 0x71C, 0x73C, and addresses with high data bits set.
- R7: A non-host write to the method-data register (word offset 0x11) gets the current flag as its verdict. Several data writes after one select write all get the same verdict.
- R8: A non-host write to any other offset gets verdict 0 and leaves the flag unchanged.
- R9: The verdict appears one cycle after the write (`verdict_valid_o` follows `wr_valid_i` with one register). While `verdict_valid_o` is 0, `verdict_addr_o` is 0. Select or data signals presented with `wr_valid_i` low have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | A write is presented this cycle |
| wr_class_i | input | CLASS_W (8) | Class ID of the write |
| wr_offset_i | input | OFF_W (12) | Word offset of the target register |
| wr_data_i | input | DATA_W (32) | Data value written |
| verdict_valid_o | output | 1 | Verdict for the write from the previous cycle is valid |
| verdict_addr_o | output | 1 | 1 when that write targets an address register |

## Verification
Two things can land on the same clock edge. A select write updates the stored flag, and a data write that follows directly behind it must already see the new flag. The bench drives a select write followed at once by a data write, with no gap between them. It does this both to set the flag and to clear it, and judges each data write's verdict against the range the preceding select value falls in. Host-class writes at the select and data offsets are also placed between a select write and a data write, to show that the stored flag survives them.

// File: rtl/cmd_class_pkg.sv
package cmd_class_pkg;
  localparam int CLASS_W_DEF  = 8;
  localparam int OFF_W_DEF    = 12;
  localparam int DATA_W_DEF   = 32;
  localparam int HOST_CLASS   = 1;
  localparam int HOST_ADDR_OFF = 'h2B;
  localparam int SEL_OFF      = 'h10;  // byte 0x40
  localparam int ARG_OFF      = 'h11;  // byte 0x44
  localparam int NUM_RANGES   = 2;

  function automatic logic [31:0] range_lo(input int idx);
    return (idx == 0) ? 32'h400 : 32'h720;
  endfunction

  function automatic logic [31:0] range_hi(input int idx);
    return (idx == 0) ? 32'h5DC : 32'h738;
  endfunction
endpackage

// File: rtl/cmd_write_decode.sv
module cmd_write_decode #(
  parameter int CLASS_W = 8,
  parameter int OFF_W   = 12
) (
  input  logic               valid_i,
  input  logic [CLASS_W-1:0] class_i,
  input  logic [OFF_W-1:0]   offset_i,
  output logic               host_addr_o,
  output logic               sel_wr_o,
  output logic               arg_wr_o
);
  import cmd_class_pkg::*;

  logic is_host;
  assign is_host     = (class_i == CLASS_W'(HOST_CLASS));
  assign host_addr_o = valid_i && is_host && (offset_i == OFF_W'(HOST_ADDR_OFF));
  assign sel_wr_o    = valid_i && !is_host && (offset_i == OFF_W'(SEL_OFF));
  assign arg_wr_o    = valid_i && !is_host && (offset_i == OFF_W'(ARG_OFF));
endmodule

// File: rtl/method_range_match.sv
module method_range_match #(
  parameter int DATA_W = 32,
  parameter int NUM_R  = 2
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              in_range_o
);
  import cmd_class_pkg::*;

  localparam int MADDR_W = DATA_W + 2;
  localparam int CMP_W   = (MADDR_W > 32) ? MADDR_W : 32;

  logic [CMP_W-1:0] maddr;
  logic [NUM_R-1:0] hit;

  assign maddr = CMP_W'({data_i, 2'b00});

  for (genvar g = 0; g < NUM_R; g++) begin : g_rng
    assign hit[g] = (maddr >= CMP_W'(range_lo(g))) && (maddr <= CMP_W'(range_hi(g)));
  end

  assign in_range_o = |hit;
endmodule

// File: rtl/addr_stash.sv
module addr_stash (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic value_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (load_i) flag_o <= value_i;
  end
endmodule

// File: rtl/cmd_addr_classifier.sv
module cmd_addr_classifier #(
  parameter int CLASS_W = cmd_class_pkg::CLASS_W_DEF,
  parameter int OFF_W   = cmd_class_pkg::OFF_W_DEF,
  parameter int DATA_W  = cmd_class_pkg::DATA_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_valid_i,
  input  logic [CLASS_W-1:0] wr_class_i,
  input  logic [OFF_W-1:0]   wr_offset_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic               verdict_valid_o,
  output logic               verdict_addr_o
);
  logic host_addr, sel_wr, arg_wr, in_range, flag, verdict_d;

  cmd_write_decode #(.CLASS_W(CLASS_W), .OFF_W(OFF_W)) u_dec (
    .valid_i    (wr_valid_i),
    .class_i    (wr_class_i),
    .offset_i   (wr_offset_i),
    .host_addr_o(host_addr),
    .sel_wr_o   (sel_wr),
    .arg_wr_o   (arg_wr)
  );

  method_range_match #(.DATA_W(DATA_W), .NUM_R(cmd_class_pkg::NUM_RANGES)) u_rng (
    .data_i    (wr_data_i),
    .in_range_o(in_range)
  );

  addr_stash u_stash (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sel_wr),
    .value_i(in_range),
    .flag_o (flag)
  );

  // data writes read the flag left by the previous select write
  assign verdict_d = host_addr || (arg_wr && flag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      verdict_valid_o <= 1'b0;
      verdict_addr_o  <= 1'b0;
    end else begin
      verdict_valid_o <= wr_valid_i;
      verdict_addr_o  <= verdict_d;
    end
  end
endmodule

// File: rtl/cmd_addr_classifier_chk.sv
module cmd_addr_classifier_chk #(
  parameter int CLASS_W = 8,
  parameter int OFF_W   = 12,
  parameter int DATA_W  = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_valid_i,
  input logic [CLASS_W-1:0] wr_class_i,
  input logic [OFF_W-1:0]   wr_offset_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic               verdict_valid_o,
  input logic               verdict_addr_o
);
  logic host_w, sel_w, arg_w, other_w;
  assign host_w  = wr_valid_i && (wr_class_i == CLASS_W'(1));
  assign sel_w   = wr_valid_i && !host_w && (wr_offset_i == OFF_W'('h10));
  assign arg_w   = wr_valid_i && !host_w && (wr_offset_i == OFF_W'('h11));
  assign other_w = wr_valid_i && !host_w && !sel_w && !arg_w;

  a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> verdict_valid_o);
  a_r9_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> !verdict_valid_o);
  a_r9_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !verdict_valid_o |-> !verdict_addr_o);
  a_r2_host_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_w |=> (verdict_addr_o == $past(wr_offset_i == OFF_W'('h2B))));
  a_r3_select_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_w |=> !verdict_addr_o);
  a_r8_other_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    other_w |=> !verdict_addr_o);
  a_r7_arg_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(arg_w) && arg_w) |=> (verdict_addr_o == $past(verdict_addr_o)));
endmodule

bind cmd_addr_classifier cmd_addr_classifier_chk #(
  .CLASS_W(CLASS_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/tb_cmd_addr_classifier.sv
module tb_cmd_addr_classifier;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  HOST = 8'd1;
  localparam logic [7:0]  ENG  = 8'h5D;
  localparam logic [11:0] SEL  = 12'h10;
  localparam logic [11:0] ARG  = 12'h11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0]  wr_class = '0;
  logic [11:0] wr_offset = '0;
  logic [31:0] wr_data = '0;
  logic v_o, a_o;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_addr_classifier dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_class_i(wr_class),
    .wr_offset_i(wr_offset), .wr_data_i(wr_data),
    .verdict_valid_o(v_o), .verdict_addr_o(a_o)
  );

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // drive one write; returns verdict sampled after the next edge
  task automatic wr(input logic [7:0] c, input logic [11:0] o, input logic [31:0] d,
                    output logic vv, output logic va);
    @(negedge clk);
    wr_valid = 1'b1; wr_class = c; wr_offset = o; wr_data = d;
    @(posedge clk); #1;
    vv = v_o; va = a_o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic vv, va;
    check("R1 valid after reset", v_o, 1'b0);
    wr(ENG, ARG, 32'h0, vv, va);
    check("R1 data before select", va, 1'b0);
    check("R9 valid one cycle later", vv, 1'b1);
    idle(1);
    @(posedge clk); #1;
    check("R9 valid drops", v_o, 1'b0);
    check("R9 addr low when idle", a_o, 1'b0);
  endtask

  task automatic t_host();
    logic vv, va;
    wr(HOST, 12'h2B, 32'h0, vv, va); check("R2 host 0x2B", va, 1'b1);
    wr(HOST, 12'h2A, 32'h0, vv, va); check("R2 host 0x2A", va, 1'b0);
    wr(HOST, 12'h2C, 32'h0, vv, va); check("R2 host 0x2C", va, 1'b0);
    wr(ENG, 12'h2B, 32'h0, vv, va);  check("R8 engine 0x2B", va, 1'b0);
    // host writes at select/data offsets must not touch the flag
    wr(ENG, SEL, 32'h100, vv, va);   check("R3 select verdict", va, 1'b0);
    wr(HOST, SEL, 32'h0, vv, va);    check("R2 host at select offset", va, 1'b0);
    wr(HOST, ARG, 32'h0, vv, va);    check("R2 host at data offset", va, 1'b0);
    wr(ENG, ARG, 32'h0, vv, va);     check("R2 flag kept after host", va, 1'b1);
    idle(1);
  endtask

  task automatic sel_then_arg(input string req, input logic [31:0] d, input logic exp);
    logic vv, va;
    wr(ENG, SEL, d, vv, va);
    check("R3 select verdict zero", va, 1'b0);
    wr(ENG, ARG, 32'hDEAD, vv, va);
    check(req, va, exp);
  endtask

  task automatic t_ranges();
    sel_then_arg("R4 low bound 0x400", 32'h100, 1'b1);
    sel_then_arg("R6 below 0x3FC", 32'hFF, 1'b0);
    sel_then_arg("R4 high bound 0x5DC", 32'h177, 1'b1);
    sel_then_arg("R6 above 0x5E0", 32'h178, 1'b0);
    sel_then_arg("R5 low bound 0x720", 32'h1C8, 1'b1);
    sel_then_arg("R6 gap 0x71C", 32'h1C7, 1'b0);
    sel_then_arg("R5 high bound 0x738", 32'h1CE, 1'b1);
    sel_then_arg("R6 above 0x73C", 32'h1CF, 1'b0);
    sel_then_arg("R4 mid range", 32'h150, 1'b1);
    sel_then_arg("R6 high data bits", 32'h4000_0100, 1'b0);
    idle(1);
  endtask

  task automatic t_reuse();
    logic vv, va;
    wr(ENG, SEL, 32'h1CA, vv, va);
    for (int i = 0; i < 3; i++) begin
      wr(ENG, ARG, 32'(i), vv, va);
      check("R7 repeated data write set", va, 1'b1);
    end
    wr(ENG, 12'h20, 32'hFF, vv, va); check("R8 other offset zero", va, 1'b0);
    wr(ENG, ARG, 32'h0, vv, va);     check("R8 flag kept after other", va, 1'b1);
    // a select presented with valid low must not clear the flag
    @(negedge clk);
    wr_valid = 1'b0; wr_class = ENG; wr_offset = SEL; wr_data = 32'h0;
    @(posedge clk); #1;
    check("R9 invalid select no verdict", a_o, 1'b0);
    wr(ENG, ARG, 32'h0, vv, va);     check("R9 invalid select ignored", va, 1'b1);
    wr(ENG, SEL, 32'h0, vv, va);
    for (int i = 0; i < 2; i++) begin
      wr(ENG, ARG, 32'h0, vv, va);
      check("R7 repeated data write clear", va, 1'b0);
    end
    idle(1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", v_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_host();
    t_ranges();
    t_reuse();
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule